// File: doc/BRIEF.md
# Dual-Ratio Rotation Rate Divider

This block takes a single stream of input ticks, which stand in for the edges of a common reference clock, and derives two rate enables from it. One path divides the ticks by a coarse ratio to produce a step enable. That enable advances a small position counter that models the positions of a rotating antenna. The other path divides the same ticks by a fine ratio to produce a count enable for a bearing display.

The default ratios are 45 and 2, with 16 positions and 360 display counts. They satisfy 45 × 16 = 2 × 360 = 720, so one full turn of the position counter and one full bearing sweep span the same 720 input ticks. Both paths start from zero at reset, so their turn boundaries stay aligned from then on.

Everything runs on one system clock, and `tick_en` marks the cycles that carry an input tick. Each terminal count is registered before it leaves its divider. The position counter reacts to that registered enable on the next edge.

Top module: `rot_rate_div`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `step_en`, `disp_en`, `rot_start` and `pos_msb` are 0 and `pos` is 0. All internal counts restart from zero.
- R2: `step_en` is high for exactly one cycle, in the cycle after the edge that samples the 45th, 90th, 135th, … input tick counted since reset. It is low in every other cycle.
- R3: `disp_en` is high for exactly one cycle, in the cycle after the edge that samples every second input tick counted since reset (the 2nd, 4th, …). It is low otherwise.
- R4: `pos` (4 bits) increments by one, from 15 back to 0, in the cycle after each `step_en` pulse. It holds its value in all other cycles.
- R5: `pos_msb` always equals bit 3 of `pos`. It falls only when `pos` returns from 15 to 0.
- R6: `rot_start` is high for exactly one cycle, namely the first cycle in which `pos` reads 0 after having read 15.
- R7: A cycle with `tick_en` low advances no divider. No `step_en` or `disp_en` follows it, and the position seen at the ports is unchanged apart from a step already in flight.
- R8: On every 720th input tick since reset, `step_en` and `disp_en` are high in the same cycle, and `rot_start` follows in the next cycle.
- R9: The parameters must satisfy STEP_DIV × POS_COUNT = DISP_DIV × BEARING_COUNT. Elaboration rejects any other combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One input tick of the common reference in this cycle |
| step_en | output | 1 | One-cycle step enable after every STEP_DIV ticks |
| disp_en | output | 1 | One-cycle display count enable after every DISP_DIV ticks |
| pos | output | 4 | Rotation position counter |
| pos_msb | output | 1 | Top bit of `pos`; its falling edge marks a new turn |
| rot_start | output | 1 | One-cycle pulse as `pos` wraps from 15 to 0 |

## Verification
The step enable and the display enable fire in the same cycle whenever the tick count is a multiple of 90. On the 720th tick this coincides with a position wrap, so the step enable, the display enable and the following turn pulse must all line up. The bench provokes these coincidences with long runs of back-to-back ticks and with runs of sparse ticks. It judges every output field in every cycle against a model that counts only ticks, and it adds an explicit check that both enables are high together on each 720-tick boundary.

// File: rtl/rot_rate_div_pkg.sv
package rot_rate_div_pkg;

   // Width needed to hold values 0 .. n-1, at least one bit.
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

   // Product check used for lock-step ratio validation.
   function automatic bit ratios_locked(input int unsigned a_div,
                                        input int unsigned a_cnt,
                                        input int unsigned b_div,
                                        input int unsigned b_cnt);
      return (a_div * a_cnt) == (b_div * b_cnt);
   endfunction

endpackage

// File: rtl/rot_tick_div.sv
module rot_tick_div
   import rot_rate_div_pkg::*;
#(
   parameter int unsigned DIV = 45
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   output logic term_o
);

   localparam int unsigned W = cnt_width(DIV);

   logic term_q;

   generate
      if (DIV < 1) begin : g_bad
         $error("rot_tick_div: DIV must be at least 1");
      end else if (DIV == 1) begin : g_pass
         // Every tick is a terminal tick; register it.
         always_ff @(posedge clk) begin
            if (!rst_n) term_q <= 1'b0;
            else        term_q <= tick_en;
         end
      end else begin : g_count
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] cnt_q;
         logic         at_last;

         assign at_last = (cnt_q == LAST);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               term_q <= 1'b0;
            end else begin
               term_q <= tick_en && at_last;
               if (tick_en) begin
                  if (at_last) cnt_q <= '0;
                  else         cnt_q <= cnt_q + 1'b1;
               end
            end
         end

         // R2 R3
         term_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            term_q |=> !term_q);

         // R7
         count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !tick_en |=> $stable(cnt_q));
      end
   endgenerate

   assign term_o = term_q;

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> !term_o);

endmodule

// File: rtl/rot_pos_ring.sv
module rot_pos_ring
   import rot_rate_div_pkg::*;
#(
   parameter int unsigned POS_COUNT = 16,
   localparam int unsigned PW       = cnt_width(POS_COUNT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_en,
   output logic [PW-1:0] pos_o,
   output logic          msb_o,
   output logic          wrap_o
);

   localparam logic [PW-1:0] LAST = PW'(POS_COUNT - 1);

   logic [PW-1:0] pos_q;
   logic          wrap_q;

   generate
      if (POS_COUNT < 2) begin : g_bad
         $error("rot_pos_ring: POS_COUNT must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q  <= '0;
         wrap_q <= 1'b0;
      end else begin
         wrap_q <= step_en && (pos_q == LAST);
         if (step_en) begin
            if (pos_q == LAST) pos_q <= '0;
            else               pos_q <= pos_q + 1'b1;
         end
      end
   end

   assign pos_o  = pos_q;
   assign msb_o  = pos_q[PW-1];
   assign wrap_o = wrap_q;

   // R4
   pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(pos_q));

   // R4
   pos_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && pos_q != LAST) |=> (pos_q == $past(pos_q) + 1'b1));

   // R6
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |-> (pos_q == '0));

   // R6
   wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |=> !wrap_q);

   // R5
   msb_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(msb_o) |-> wrap_q);

endmodule

// File: rtl/rot_rate_div.sv
module rot_rate_div
   import rot_rate_div_pkg::*;
#(
   parameter int unsigned STEP_DIV      = 45,
   parameter int unsigned DISP_DIV      = 2,
   parameter int unsigned POS_COUNT     = 16,
   parameter int unsigned BEARING_COUNT = 360
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   output logic       step_en,
   output logic       disp_en,
   output logic [3:0] pos,
   output logic       pos_msb,
   output logic       rot_start
);

   localparam int unsigned PW = cnt_width(POS_COUNT);

   // R9
   generate
      if (!ratios_locked(STEP_DIV, POS_COUNT, DISP_DIV, BEARING_COUNT)) begin : g_unlocked
         $error("rot_rate_div: STEP_DIV*POS_COUNT must equal DISP_DIV*BEARING_COUNT");
      end
      if (PW != 4) begin : g_width
         $error("rot_rate_div: POS_COUNT must need a 4-bit position");
      end
   endgenerate

   logic          step_w;
   logic          disp_w;
   logic [PW-1:0] pos_w;
   logic          msb_w;
   logic          wrap_w;

   rot_tick_div #(.DIV(STEP_DIV)) u_step_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_en(tick_en),
      .term_o (step_w)
   );

   rot_tick_div #(.DIV(DISP_DIV)) u_disp_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_en(tick_en),
      .term_o (disp_w)
   );

   rot_pos_ring #(.POS_COUNT(POS_COUNT)) u_ring (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_en(step_w),
      .pos_o  (pos_w),
      .msb_o  (msb_w),
      .wrap_o (wrap_w)
   );

   assign step_en   = step_w;
   assign disp_en   = disp_w;
   assign pos       = 4'(pos_w);
   assign pos_msb   = msb_w;
   assign rot_start = wrap_w;

   // R8
   turn_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rot_start |-> $past(step_en));

   // R5
   msb_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_msb == pos[3]);

endmodule

// File: tb/tb_rot_rate_div.sv
module tb_rot_rate_div;

   typedef struct {
      bit       step;
      bit       disp;
      bit [3:0] pos;
      bit       rot;
      bit       idle;
      bit       bnd;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       step_en, disp_en, pos_msb, rot_start;
   logic [3:0] pos;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   exp_t q[$];

   // Independent model state: counts only ticks since reset.
   int       m45 = 0;
   int       m2 = 0;
   int       ticks = 0;
   bit [3:0] mpos = 0;
   bit       mstep = 0;

   always #2.5 clk = ~clk;

   rot_rate_div dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .step_en(step_en), .disp_en(disp_en), .pos(pos),
      .pos_msb(pos_msb), .rot_start(rot_start)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tick_en = 1'b0;
      q.delete();
      m45 = 0; m2 = 0; ticks = 0; mpos = 0; mstep = 0;
      repeat (3) @(negedge clk);
      // R1 during reset
      check(step_en == 0 && disp_en == 0 && rot_start == 0, "R1 enables in reset",
            {step_en, disp_en, rot_start}, 0);
      check(pos == 0 && pos_msb == 0, "R1 position in reset", pos, 0);
      rst_n = 1'b1;
   endtask

   // Driver: one cycle, pushes the outputs expected after the next edge.
   task automatic drive(input bit t);
      exp_t e;
      @(negedge clk);
      tick_en = t;
      e.rot  = mstep && (mpos == 4'd15);
      e.pos  = mstep ? mpos + 4'd1 : mpos;
      e.step = t && (m45 == 44);
      e.disp = t && (m2 == 1);
      e.idle = !t;
      if (t) begin
         m45 = (m45 == 44) ? 0 : m45 + 1;
         m2  = (m2 == 1) ? 0 : 1;
         ticks++;
      end
      e.bnd = t && (ticks % 720 == 0);
      mpos  = e.pos;
      mstep = e.step;
      q.push_back(e);
   endtask

   // Monitor: compares just after each edge.
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(step_en == e.step, e.idle ? "R7 step after idle" : "R2 step_en",
               step_en, e.step);
         check(disp_en == e.disp, e.idle ? "R7 disp after idle" : "R3 disp_en",
               disp_en, e.disp);
         check(pos == e.pos, "R4 pos", pos, e.pos);
         check(pos_msb == e.pos[3], "R5 pos_msb", pos_msb, e.pos[3]);
         check(rot_start == e.rot, "R6 rot_start", rot_start, e.rot);
         if (e.bnd) check(step_en && disp_en, "R8 turn boundary coincidence",
                          {step_en, disp_en}, 3);
      end
   end

   initial begin
      do_reset();
      @(posedge clk); #1;
      // R1 first cycle after release
      check(pos == 0 && step_en == 0 && disp_en == 0, "R1 after release", pos, 0);
      // Back-to-back ticks across two full turns.
      for (int i = 0; i < 1440; i++) drive(1'b1);
      // Idle window: nothing may advance.
      for (int i = 0; i < 20; i++) drive(1'b0);
      // Sparse ticks, one in three cycles.
      for (int i = 0; i < 800; i++) begin
         drive(1'b1);
         drive(1'b0);
         drive(1'b0);
      end
      // Mixed burst pattern.
      for (int i = 0; i < 700; i++) drive((i % 5) != 3);
      for (int i = 0; i < 3; i++) drive(1'b0);
      // Reset mid-turn and restart.
      do_reset();
      for (int i = 0; i < 760; i++) drive(1'b1);
      drive(1'b0);
      drive(1'b0);
      @(posedge clk); #2;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule